// File: doc/BRIEF.md
# CAN Bit-Time Timestamp Counter

This block keeps a 16-bit counter that advances once per CAN bit time. It runs off the bit-clock domain of a CAN controller, where a bit-timing generator supplies a one-cycle tick for every nominal bit. Ticks arrive both while a frame is on the wire and while the bus is idle. A freeze input stops the count. The protocol engine pulses a strobe when the identifier field of any frame begins, and the counter value at that moment is kept aside. That value becomes the visible message timestamp only when the engine later reports that the frame completed successfully.

The host loads a new counter value from its own clock domain. The written word is placed in a holding register, and a toggle-based request is raised towards the bit domain. The bit domain copies the held word into the counter and returns a toggle-based acknowledge. Software polls a busy flag to learn when its write has taken effect. The flag stays set from the write until the acknowledge has been synchronised back into the host domain.

Top module: `can_ts_timer`

## Requirements
- R1: After reset the live count and the timestamp both read 0x0000, and the write-busy flag reads 0.
- R2: Each bit-domain cycle with `bitTick` high and `freeze` low raises the count by exactly one. Cycles without a tick leave it unchanged.
- R3: The count wraps from 0xFFFF to 0x0000 on the next tick.
- R4: While `freeze` is high, ticks have no effect on the count. Counting resumes from the held value once `freeze` drops.
- R5: A cycle with `idStart` high samples the count as it stood before that cycle's edge. The `timestamp` output takes that sample only at the edge where `frameOk` is high.
- R6: If an identifier start is followed by another identifier start with no `frameOk` in between, `timestamp` keeps its earlier committed value. The next successful frame then delivers the most recent sample.
- R7: A host write accepted while `wrBusy` is 0 sets `wrBusy` on the following host edge. Once `wrBusy` returns to 0, the count equals the written value, provided no tick occurred after the load.
- R8: A host write presented while `wrBusy` is 1 is discarded. The counter later receives only the value that was accepted first.
- R9: When a write commits in the same bit-domain cycle as a tick, the count takes the written value unchanged, with no increment.
- R10: A `frameOk` strobe with no identifier start since the last commit leaves `timestamp` unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| rstN | input | 1 | Asynchronous active-low reset for both domains |
| hostClk | input | 1 | Host register-port clock |
| hostWrEn | input | 1 | Host write strobe for the counter |
| hostWrData | input | 16 | Value to load into the counter |
| wrBusy | output | 1 | High while a host write has not yet reached the counter |
| canClk | input | 1 | CAN controller bit-domain clock |
| bitTick | input | 1 | One-cycle pulse per elapsed bit time |
| freeze | input | 1 | Holds the count while high |
| idStart | input | 1 | Pulse at the start of a frame's identifier field |
| frameOk | input | 1 | Pulse when a frame was sent or received without error |
| count | output | 16 | Live counter value |
| timestamp | output | 16 | Last committed identifier-start sample |

## Verification
A lost or doubled increment shows up as an off-by-one `count` at the edge that follows the tick, so the directed tick runs compare right after every pulse. A handshake toggle that is stuck or inverted either leaves `wrBusy` high past a bounded wait or lets a second write through. In both cases the counter ends up holding the wrong value once the busy flag drops. A wrong capture or arming flag becomes visible on `timestamp` one bit-domain edge after `frameOk`. Ignored strobes are checked by reading `timestamp` right after them.

// File: rtl/can_ts_pkg.sv
package can_ts_pkg;
  typedef struct packed {
    logic load;     // copy held host word into counter
    logic tick;     // advance counter by one
    logic capture;  // sample counter at identifier start
    logic commit;   // publish sample as timestamp
  } tsStrobes_t;
endpackage

// File: rtl/can_ts_sync.sv
module can_ts_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rstN,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] chain;

  generate
    if (STAGES == 1) begin : g_one
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) chain <= '0;
        else       chain <= d;
      end
    end else begin : g_many
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) chain <= '0;
        else       chain <= {chain[STAGES-2:0], d};
      end
    end
  endgenerate

  assign q = chain[STAGES-1];
endmodule

// File: rtl/can_ts_ctrl.sv
module can_ts_ctrl
  import can_ts_pkg::*;
#(
  parameter int CNT_W       = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic             rstN,
  input  logic             hostClk,
  input  logic             hostWrEn,
  input  logic [CNT_W-1:0] hostWrData,
  output logic             wrBusy,
  input  logic             canClk,
  input  logic             bitTick,
  input  logic             freeze,
  input  logic             idStart,
  input  logic             frameOk,
  output tsStrobes_t       str,
  output logic [CNT_W-1:0] loadData
);
  // host domain
  logic [CNT_W-1:0] holdReg;
  logic             reqTgl;
  logic             ackSeen;
  logic             wrAccept;

  // bit domain
  logic reqSeen;
  logic ackTgl;
  logic armed;

  can_ts_sync #(.STAGES(SYNC_STAGES)) ackSync_i (
    .clk(hostClk), .rstN(rstN), .d(ackTgl), .q(ackSeen)
  );
  can_ts_sync #(.STAGES(SYNC_STAGES)) reqSync_i (
    .clk(canClk), .rstN(rstN), .d(reqTgl), .q(reqSeen)
  );

  assign wrBusy   = reqTgl ^ ackSeen;
  assign wrAccept = hostWrEn && !wrBusy;

  always_ff @(posedge hostClk or negedge rstN) begin
    if (!rstN) begin
      holdReg <= '0;
      reqTgl  <= 1'b0;
    end else if (wrAccept) begin
      holdReg <= hostWrData;
      reqTgl  <= ~reqTgl;
    end
  end

  always_ff @(posedge canClk or negedge rstN) begin
    if (!rstN) begin
      ackTgl <= 1'b0;
      armed  <= 1'b0;
    end else begin
      ackTgl <= reqSeen;
      if (idStart)      armed <= 1'b1;
      else if (frameOk) armed <= 1'b0;
    end
  end

  assign str.load    = reqSeen ^ ackTgl;
  assign str.tick    = bitTick && !freeze;
  assign str.capture = idStart;
  assign str.commit  = frameOk && armed;
  assign loadData    = holdReg;

  AST_HOLD_STABLE: assert property (@(posedge hostClk) disable iff (!rstN)
    wrBusy |=> $stable(holdReg)); // R8

  AST_BUSY_AFTER_WRITE: assert property (@(posedge hostClk) disable iff (!rstN)
    wrAccept |=> wrBusy); // R7

  AST_NO_LOAD_WHILE_IDLE: assert property (@(posedge canClk) disable iff (!rstN)
    str.load |=> !str.load); // R7
endmodule

// File: rtl/can_ts_datapath.sv
module can_ts_datapath
  import can_ts_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             canClk,
  input  logic             rstN,
  input  tsStrobes_t       str,
  input  logic [CNT_W-1:0] loadData,
  output logic [CNT_W-1:0] count,
  output logic [CNT_W-1:0] timestamp
);
  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  logic [CNT_W-1:0] sampleReg;

  always_ff @(posedge canClk or negedge rstN) begin
    if (!rstN) begin
      count     <= '0;
      sampleReg <= '0;
      timestamp <= '0;
    end else begin
      if (str.load)      count <= loadData;
      else if (str.tick) count <= count + ONE;
      if (str.commit)  timestamp <= sampleReg;
      if (str.capture) sampleReg <= count;
    end
  end

  AST_LOAD_WINS: assert property (@(posedge canClk) disable iff (!rstN)
    str.load |=> count == $past(loadData)); // R9

  AST_TICK_STEP: assert property (@(posedge canClk) disable iff (!rstN)
    (str.tick && !str.load) |=> count == $past(count) + ONE); // R2

  AST_IDLE_HOLD: assert property (@(posedge canClk) disable iff (!rstN)
    (!str.tick && !str.load) |=> $stable(count)); // R4

  AST_TS_HOLD: assert property (@(posedge canClk) disable iff (!rstN)
    !str.commit |=> $stable(timestamp)); // R6
endmodule

// File: rtl/can_ts_timer.sv
module can_ts_timer
  import can_ts_pkg::*;
#(
  parameter int CNT_W       = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic             rstN,
  input  logic             hostClk,
  input  logic             hostWrEn,
  input  logic [CNT_W-1:0] hostWrData,
  output logic             wrBusy,
  input  logic             canClk,
  input  logic             bitTick,
  input  logic             freeze,
  input  logic             idStart,
  input  logic             frameOk,
  output logic [CNT_W-1:0] count,
  output logic [CNT_W-1:0] timestamp
);
  tsStrobes_t       str;
  logic [CNT_W-1:0] loadData;

  can_ts_ctrl #(.CNT_W(CNT_W), .SYNC_STAGES(SYNC_STAGES)) ctrl_i (
    .rstN(rstN), .hostClk(hostClk), .hostWrEn(hostWrEn), .hostWrData(hostWrData),
    .wrBusy(wrBusy), .canClk(canClk), .bitTick(bitTick), .freeze(freeze),
    .idStart(idStart), .frameOk(frameOk), .str(str), .loadData(loadData)
  );

  can_ts_datapath #(.CNT_W(CNT_W)) dp_i (
    .canClk(canClk), .rstN(rstN), .str(str), .loadData(loadData),
    .count(count), .timestamp(timestamp)
  );
endmodule

// File: tb/can_ts_timer_tb_top.sv
module can_ts_timer_tb_top;
  localparam int CAN_PERIOD  = 10;
  localparam int HOST_PERIOD = 14;

  logic        rstN = 1'b0;
  logic        hostClk = 1'b0;
  logic        canClk = 1'b0;
  logic        hostWrEn = 1'b0;
  logic [15:0] hostWrData = '0;
  logic        bitTick = 1'b0;
  logic        freeze = 1'b0;
  logic        idStart = 1'b0;
  logic        frameOk = 1'b0;
  logic        wrBusy;
  logic [15:0] count;
  logic [15:0] timestamp;

  int compared = 0;
  int mismatched = 0;

  always #(HOST_PERIOD/2) hostClk = ~hostClk;
  always #(CAN_PERIOD/2)  canClk  = ~canClk;

  can_ts_timer dut_i (
    .rstN(rstN), .hostClk(hostClk), .hostWrEn(hostWrEn), .hostWrData(hostWrData),
    .wrBusy(wrBusy), .canClk(canClk), .bitTick(bitTick), .freeze(freeze),
    .idStart(idStart), .frameOk(frameOk), .count(count), .timestamp(timestamp)
  );

  task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge canClk) bitTick = 1'b1;
      @(negedge canClk) bitTick = 1'b0;
    end
  endtask

  task automatic hostWrite(input logic [15:0] v);
    @(negedge hostClk) begin hostWrEn = 1'b1; hostWrData = v; end
    @(negedge hostClk) hostWrEn = 1'b0;
  endtask

  task automatic waitIdle();
    for (int i = 0; i < 50 && wrBusy; i++) @(negedge hostClk);
    check("R7 busy clears", {15'd0, wrBusy}, 16'd0);
    @(negedge canClk);
  endtask

  task automatic pulseId();
    @(negedge canClk) idStart = 1'b1;
    @(negedge canClk) idStart = 1'b0;
  endtask

  task automatic pulseOk();
    @(negedge canClk) frameOk = 1'b1;
    @(negedge canClk) frameOk = 1'b0;
  endtask

  task automatic testReset();
    check("R1 count", count, 16'h0000);
    check("R1 timestamp", timestamp, 16'h0000);
    check("R1 busy", {15'd0, wrBusy}, 16'd0);
  endtask

  task automatic testCount();
    logic [15:0] base = count;
    ticks(1);  check("R2 one tick", count, base + 16'd1);
    repeat (4) @(negedge canClk);
    check("R2 no tick holds", count, base + 16'd1);
    ticks(5);  check("R2 five ticks", count, base + 16'd6);
  endtask

  task automatic testWrite();
    hostWrite(16'h1234);
    check("R7 busy set", {15'd0, wrBusy}, 16'd1);
    waitIdle();
    check("R7 value loaded", count, 16'h1234);
  endtask

  task automatic testWrap();
    hostWrite(16'hFFFE);
    waitIdle();
    ticks(1); check("R3 reach max", count, 16'hFFFF);
    ticks(1); check("R3 wrap", count, 16'h0000);
    ticks(1); check("R3 after wrap", count, 16'h0001);
  endtask

  task automatic testFreeze();
    logic [15:0] base = count;
    @(negedge canClk) freeze = 1'b1;
    ticks(3);
    check("R4 frozen", count, base);
    @(negedge canClk) freeze = 1'b0;
    ticks(2);
    check("R4 resumed", count, base + 16'd2);
  endtask

  task automatic testIgnoredWrite();
    @(negedge hostClk) begin hostWrEn = 1'b1; hostWrData = 16'hAAAA; end
    @(negedge hostClk) hostWrData = 16'h5555;
    @(negedge hostClk) hostWrEn = 1'b0;
    waitIdle();
    check("R8 second write discarded", count, 16'hAAAA);
  endtask

  task automatic testTickLoad();
    bit seen = 0;
    @(negedge canClk) bitTick = 1'b1;
    hostWrite(16'h7000);
    for (int i = 0; i < 40; i++) begin
      @(negedge canClk);
      if (count == 16'h7000) seen = 1;
    end
    bitTick = 1'b0;
    check("R9 exact write value seen", {15'd0, seen}, 16'd1);
  endtask

  task automatic testFrames();
    logic [15:0] a, c;
    hostWrite(16'h0100);
    waitIdle();
    a = count;
    pulseId();
    ticks(3);
    check("R5 not before success", timestamp, 16'h0000);
    pulseOk();
    check("R5 commit", timestamp, a);
    ticks(2);
    pulseId();                 // aborted frame
    ticks(2);
    check("R6 abort keeps", timestamp, a);
    c = count;
    pulseId();
    ticks(4);
    pulseOk();
    check("R6 latest sample", timestamp, c);
    ticks(2);
    pulseOk();
    check("R10 stray success ignored", timestamp, c);
  endtask

  initial begin
    #(CAN_PERIOD * 150000);
    mismatched++;
    $display("FAIL watchdog actual=running expected=done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    repeat (3) @(negedge canClk);
    testReset();
    rstN = 1'b1;
    repeat (2) @(negedge canClk);
    testReset();
    testCount();
    testWrite();
    testWrap();
    testFreeze();
    testIgnoredWrite();
    testTickLoad();
    testFrames();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule